// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This unit decides which of four hardware thread contexts owns the fetch port in each clock cycle, and it supplies the program counter of that thread. Every context has its own PC register, so handing the port to another thread costs no save or restore cycle. Two switching policies are built in, and a mode input chooses between them. In interleaved (fine) mode the grant moves around the threads every cycle and skips any thread that reports a stall. In block (coarse) mode one thread keeps the port until it reports a long-latency stall. The unit then asks for a pipeline flush and hides fetch for a fixed refill window.

A preferred-thread override and a per-thread weight shape the share each thread receives. The fetch stage consumes `sel_id`, `fetch_valid` and `fetch_pc` in the same cycle. A set `flush_req` tells the pipeline to drain the instructions of the outgoing thread. Redirect inputs let the back end load a new PC into any context.

Top module: `mt_fetch_select`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every PC equals `RESET_PC` and the rotation starts at thread 0. With all threads ready, weights 1, fine mode and no preference, the first cycle after reset grants thread 0 with `fetch_pc` = `RESET_PC`.
- R2: In fine mode (`mode_coarse`=0), with weights of 1 and no stalls, the grant moves to the next thread ID every cycle (0,1,2,3,0,...) and `fetch_valid` is 1.
- R3: In fine mode a thread with `stall_short` or `stall_long` set is passed over. The next ready thread in rotation order, starting from the rotation pointer, is granted in the same cycle.
- R4: In fine mode a thread whose weight field `weight[t*WT_W +: WT_W]` holds w receives up to w consecutive grants per turn (a weight of 0 counts as 1). If the thread stalls during its turn, the rest of its turn is lost.
- R5: When every thread is stalled, `fetch_valid` is 0, `sel_id` keeps its previous value and the rotation state does not move.
- R6: A thread with `redir_valid[t]` set loads `redir_pc[t*PC_W +: PC_W]` at the next edge. Otherwise a granted thread (`fetch_valid`=1 with `sel_id`=t) advances its PC by 4. `fetch_pc` always shows the PC of `sel_id`.
- R7: In coarse mode the current thread stays selected during a short stall. It does not switch, and `fetch_valid` is 0 only while the stall lasts.
- R8: In coarse mode a long stall on the current thread, when another thread is ready, produces one cycle with `flush_req`=1 and `fetch_valid`=0. In that cycle `sel_id` names the new thread, which is the first ready thread after the current one. `fetch_valid` then stays 0 for exactly `REFILL_CYC` (3) more cycles. `flush_req` is only ever 1 in coarse mode.
- R9: With `pref_en`=1 and thread `pref_id` ready, that thread is granted in fine mode. In coarse mode it takes the port through a flush switch. Other threads are chosen only while it is stalled.
- R10: A mode change takes effect at the next cycle boundary. A refill already counting runs to completion in either mode before any grant.
- R11: `fetch_valid` is never 1 for a thread whose `stall_short` or `stall_long` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_coarse | input | 1 | 0: interleave each cycle; 1: switch on long stall |
| pref_en | input | 1 | Enables the preferred-thread override |
| pref_id | input | 2 | Preferred thread ID |
| stall_short | input | 4 | Per-thread short stall |
| stall_long | input | 4 | Per-thread long-latency stall |
| weight | input | 12 | Per-thread weight, 3 bits per thread, thread t at bits t*3+2:t*3 |
| redir_valid | input | 4 | Per-thread PC redirect strobe |
| redir_pc | input | 128 | Per-thread redirect target, thread t at bits t*32+31:t*32 |
| sel_id | output | 2 | Selected thread ID |
| fetch_valid | output | 1 | Fetch slot is valid for `sel_id` |
| fetch_pc | output | 32 | PC of the selected thread |
| flush_req | output | 1 | Drain request on a coarse switch |

## Verification
The hardest state to reach from the ports is a mode change that lands inside a refill window. A long stall must first push a coarse switch, and the mode must then flip before the three hidden cycles have passed. Directed sequences build exactly that case in both directions. They also build a preferred thread that pulls the port away in coarse mode. A long random run then mixes sparse mode flips, stall bursts, weight changes and redirects, so that switches overlap with redirects and preference changes. Every cycle is compared against a cycle model kept in the bench.

// File: rtl/mtf_pkg.sv
// Package mtf_pkg
// Shared constants and helpers for the fetch thread selector.
// Assumes weights are unsigned and that a weight of zero means one slot.
package mtf_pkg;

    localparam int unsigned MTF_PC_STEP = 4;

    // Effective number of consecutive slots for a raw weight value.
    function automatic int unsigned weight_eff(input int unsigned raw);
        return (raw == 0) ? 1 : raw;
    endfunction

endpackage

// File: rtl/mtf_rot_pick.sv
// Module mtf_rot_pick
// Rotating find-first: returns the first set request at or after `start`,
// wrapping modulo N. Assumes N is a power of two so that index arithmetic
// wraps by width truncation.
module mtf_rot_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);

    logic [IW-1:0] pos;

    // Scan from the farthest offset down so the nearest requester wins.
    always_comb begin
        found = 1'b0;
        idx   = start;
        pos   = start;
        for (int k = N - 1; k >= 0; k--) begin
            pos = start + IW'(k);
            if (req[pos]) begin
                found = 1'b1;
                idx   = pos;
            end
        end
    end

endmodule

// File: rtl/mtf_pc_bank.sv
// Module mtf_pc_bank
// One PC register per thread context. A redirect takes priority over the
// sequential advance of the granted thread. Assumes the read index is valid.
module mtf_pc_bank #(
    parameter int          N       = 4,
    parameter int          PCW     = 32,
    parameter logic [PCW-1:0] RST_PC = '0,
    localparam int         IW      = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     redir_valid,
    input  logic [N*PCW-1:0] redir_pc,
    input  logic             adv_valid,
    input  logic [IW-1:0]    adv_id,
    input  logic [IW-1:0]    rd_id,
    output logic [PCW-1:0]   rd_pc
);

    logic [PCW-1:0] pc_q [N];

    genvar t;
    generate
        for (t = 0; t < N; t++) begin : g_ctx
            // Per-context PC: reset vector, redirect, or step on grant.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pc_q[t] <= RST_PC;
                end else if (redir_valid[t]) begin
                    pc_q[t] <= redir_pc[t*PCW +: PCW];
                end else if (adv_valid && (adv_id == IW'(t))) begin
                    pc_q[t] <= pc_q[t] + PCW'(mtf_pkg::MTF_PC_STEP);
                end
            end
        end
    endgenerate

    // Read port for the selected thread.
    always_comb rd_pc = pc_q[rd_id];

endmodule

// File: rtl/mtf_sched.sv
// Module mtf_sched
// Thread scheduling state machine for both policies. Fine mode rotates with
// weighted turns and a preferred-thread override; coarse mode holds one
// thread until a long stall or a ready preferred thread forces a flush
// switch followed by a fixed refill window. Outputs are combinational from
// state and the current stall inputs; they are forced idle during reset.
module mtf_sched #(
    parameter int N      = 4,
    parameter int WW     = 3,
    parameter int REFILL = 3,
    localparam int IW    = (N > 1) ? $clog2(N) : 1,
    localparam int RCW   = $clog2(REFILL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_coarse,
    input  logic            pref_en,
    input  logic [IW-1:0]   pref_id,
    input  logic [N-1:0]    stall_short,
    input  logic [N-1:0]    stall_long,
    input  logic [N*WW-1:0] weight,
    output logic [IW-1:0]   sel_id,
    output logic            fetch_valid,
    output logic            flush_req
);

    logic [IW-1:0]  rr_ptr, last_id;
    logic [WW-1:0]  slot_cnt;
    logic [RCW-1:0] refill;

    logic [N-1:0]   rdy, other_rdy;
    logic           f_found, c_found;
    logic [IW-1:0]  f_idx, c_idx;
    logic [IW-1:0]  c_start;
    logic           pref_rdy;

    logic           grant, flush;
    logic [IW-1:0]  gid;
    logic [IW-1:0]  n_ptr;
    logic [WW-1:0]  n_cnt;
    logic [RCW-1:0] n_refill;
    logic [WW:0]    used, eff;

    // Ready vectors for both pickers.
    always_comb begin
        rdy       = ~(stall_short | stall_long);
        other_rdy = rdy & ~(N'(1) << last_id);
        c_start   = last_id + IW'(1);
        pref_rdy  = pref_en && rdy[pref_id];
    end

    mtf_rot_pick #(.N(N)) u_fine_pick (
        .req   (rdy),
        .start (rr_ptr),
        .found (f_found),
        .idx   (f_idx)
    );

    mtf_rot_pick #(.N(N)) u_coarse_pick (
        .req   (other_rdy),
        .start (c_start),
        .found (c_found),
        .idx   (c_idx)
    );

    // Grant decision and next-state computation for one cycle.
    always_comb begin
        grant    = 1'b0;
        flush    = 1'b0;
        gid      = last_id;
        n_ptr    = rr_ptr;
        n_cnt    = slot_cnt;
        n_refill = refill;
        eff      = (WW+1)'(mtf_pkg::weight_eff(32'(weight[f_idx*WW +: WW])));
        used     = (f_idx == rr_ptr) ? ({1'b0, slot_cnt} + (WW+1)'(1)) : (WW+1)'(1);
        if (refill != '0) begin
            n_refill = refill - RCW'(1);
        end else if (!mode_coarse) begin
            if (pref_rdy) begin
                grant = 1'b1;
                gid   = pref_id;
            end else if (f_found) begin
                grant = 1'b1;
                gid   = f_idx;
                if (used >= eff) begin
                    n_ptr = f_idx + IW'(1);
                    n_cnt = '0;
                end else begin
                    n_ptr = f_idx;
                    n_cnt = used[WW-1:0];
                end
            end
        end else begin
            if (pref_rdy && (pref_id != last_id)) begin
                flush    = 1'b1;
                gid      = pref_id;
                n_refill = RCW'(REFILL);
            end else if (stall_long[last_id] && c_found) begin
                flush    = 1'b1;
                gid      = c_idx;
                n_refill = RCW'(REFILL);
            end else if (rdy[last_id]) begin
                grant = 1'b1;
            end
        end
    end

    // Outputs, held idle while reset is asserted.
    always_comb begin
        fetch_valid = grant & rst_n;
        flush_req   = flush & rst_n;
        sel_id      = rst_n ? gid : last_id;
    end

    // Scheduler state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr   <= '0;
            last_id  <= '0;
            slot_cnt <= '0;
            refill   <= '0;
        end else begin
            rr_ptr   <= n_ptr;
            slot_cnt <= n_cnt;
            refill   <= n_refill;
            if (grant || flush) last_id <= gid;
        end
    end

endmodule

// File: rtl/mt_fetch_select.sv
// Module mt_fetch_select
// Top of the multithreaded fetch selector: the scheduler picks the thread,
// the PC bank supplies and advances per-thread PCs. Assumes N_THR is a
// power of two and that weights and redirects are stable around the edge.
module mt_fetch_select #(
    parameter int          N_THR      = 4,
    parameter int          PC_W       = 32,
    parameter int          WT_W       = 3,
    parameter int          REFILL_CYC = 3,
    parameter logic [31:0] RESET_PC   = 32'h0000_1000,
    localparam int         IW         = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_coarse,
    input  logic                 pref_en,
    input  logic [IW-1:0]        pref_id,
    input  logic [N_THR-1:0]     stall_short,
    input  logic [N_THR-1:0]     stall_long,
    input  logic [N_THR*WT_W-1:0] weight,
    input  logic [N_THR-1:0]     redir_valid,
    input  logic [N_THR*PC_W-1:0] redir_pc,
    output logic [IW-1:0]        sel_id,
    output logic                 fetch_valid,
    output logic [PC_W-1:0]      fetch_pc,
    output logic                 flush_req
);

    mtf_sched #(
        .N      (N_THR),
        .WW     (WT_W),
        .REFILL (REFILL_CYC)
    ) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_coarse (mode_coarse),
        .pref_en     (pref_en),
        .pref_id     (pref_id),
        .stall_short (stall_short),
        .stall_long  (stall_long),
        .weight      (weight),
        .sel_id      (sel_id),
        .fetch_valid (fetch_valid),
        .flush_req   (flush_req)
    );

    mtf_pc_bank #(
        .N      (N_THR),
        .PCW    (PC_W),
        .RST_PC (PC_W'(RESET_PC))
    ) u_pcs (
        .clk         (clk),
        .rst_n       (rst_n),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .adv_valid   (fetch_valid),
        .adv_id      (sel_id),
        .rd_id       (sel_id),
        .rd_pc       (fetch_pc)
    );

endmodule

// File: rtl/mt_fetch_select_chk.sv
// Module mt_fetch_select_chk
// Property checker for mt_fetch_select, attached with bind. Observes only
// the top-level ports.
module mt_fetch_select_chk #(
    parameter int  N_THR = 4,
    localparam int IW    = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_coarse,
    input logic             pref_en,
    input logic [IW-1:0]    pref_id,
    input logic [N_THR-1:0] stall_short,
    input logic [N_THR-1:0] stall_long,
    input logic [IW-1:0]    sel_id,
    input logic             fetch_valid,
    input logic             flush_req
);

    logic [N_THR-1:0] busy;
    always_comb busy = stall_short | stall_long;

    // R11: a valid fetch never goes to a stalled thread.
    a_r11_no_stalled_grant: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> !busy[sel_id]);

    // R5: with every thread stalled, nothing is fetched and the ID holds.
    a_r5_all_stalled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> (!fetch_valid && (sel_id == $past(sel_id))));

    // R8: a flush appears only in coarse mode.
    a_r8_flush_coarse_only: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> mode_coarse);

    // R8: the cycle after a flush is a hidden refill cycle.
    a_r8_refill_first: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (!fetch_valid && !flush_req));

    // R8: the refill window still hides fetch two and three cycles on.
    a_r8_refill_late: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_req, 2) || $past(flush_req, 3)) |-> !fetch_valid);

    // R9: a ready preferred thread wins every valid fine-mode slot.
    a_r9_pref_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_coarse && pref_en && !busy[pref_id] && fetch_valid) |-> (sel_id == pref_id));

endmodule

bind mt_fetch_select mt_fetch_select_chk #(.N_THR(N_THR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_coarse (mode_coarse),
    .pref_en     (pref_en),
    .pref_id     (pref_id),
    .stall_short (stall_short),
    .stall_long  (stall_long),
    .sel_id      (sel_id),
    .fetch_valid (fetch_valid),
    .flush_req   (flush_req)
);

// File: tb/sim_mt_fetch_select.sv
// Bench for mt_fetch_select: directed sequences plus seeded random stimulus,
// each cycle compared against a cycle model kept in the bench.
module sim_mt_fetch_select;

    localparam int          NT   = 4;
    localparam int          PW   = 32;
    localparam int          WW   = 3;
    localparam logic [31:0] RVEC = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_c;
    logic          pref_en;
    logic [1:0]    pref_id;
    logic [3:0]    ss, sl;
    logic [11:0]   wt;
    logic [3:0]    rv;
    logic [127:0]  rpc;
    logic [1:0]    sel;
    logic          fv, fl;
    logic [31:0]   fpc;

    int nchecks = 0;
    int nerr    = 0;

    always #5 clk = ~clk;

    mt_fetch_select u0 (
        .clk (clk), .rst_n (rst_n), .mode_coarse (mode_c),
        .pref_en (pref_en), .pref_id (pref_id),
        .stall_short (ss), .stall_long (sl), .weight (wt),
        .redir_valid (rv), .redir_pc (rpc),
        .sel_id (sel), .fetch_valid (fv), .fetch_pc (fpc), .flush_req (fl)
    );

    // Model state and next state.
    int          m_ptr, m_cnt, m_last, m_refill;
    logic [31:0] m_pc [4];
    int          n_ptr, n_cnt, n_last, n_refill;
    logic [31:0] n_pc [4];

    function automatic int wgt(input int t);
        int w;
        w = int'(wt[t*WW +: WW]);
        return (w == 0) ? 1 : w;
    endfunction

    function automatic bit ready(input int t);
        return !(ss[t] || sl[t]);
    endfunction

    task automatic model_reset();
        m_ptr = 0; m_cnt = 0; m_last = 0; m_refill = 0;
        for (int t = 0; t < 4; t++) m_pc[t] = RVEC;
    endtask

    // Expected outputs and next state from the requirements.
    task automatic model_eval(output bit e_v, output int e_s, output bit e_f);
        int g, used, c;
        bit hit;
        e_v = 0; e_f = 0; e_s = m_last;
        n_ptr = m_ptr; n_cnt = m_cnt; n_last = m_last; n_refill = m_refill;
        if (m_refill != 0) begin
            n_refill = m_refill - 1;                       // R10 / R8 refill
        end else if (!mode_c) begin
            if (pref_en && ready(int'(pref_id))) begin     // R9
                e_v = 1; e_s = int'(pref_id);
            end else begin
                hit = 0; g = 0;
                for (int k = 0; k < 4; k++) begin          // R3 rotation
                    c = (m_ptr + k) % 4;
                    if (!hit && ready(c)) begin hit = 1; g = c; end
                end
                if (hit) begin                             // R4 weighted turn
                    e_v = 1; e_s = g;
                    used = (g == m_ptr) ? m_cnt + 1 : 1;
                    if (used >= wgt(g)) begin n_ptr = (g + 1) % 4; n_cnt = 0; end
                    else begin n_ptr = g; n_cnt = used; end
                end
            end
        end else begin
            hit = 0; g = 0;
            for (int k = 1; k < 4; k++) begin
                c = (m_last + k) % 4;
                if (!hit && ready(c)) begin hit = 1; g = c; end
            end
            if (pref_en && ready(int'(pref_id)) && int'(pref_id) != m_last) begin
                e_f = 1; e_s = int'(pref_id); n_refill = 3;
            end else if (sl[m_last] && hit) begin           // R8
                e_f = 1; e_s = g; n_refill = 3;
            end else if (ready(m_last)) begin               // R7
                e_v = 1;
            end
        end
        if (e_v || e_f) n_last = e_s;
        for (int t = 0; t < 4; t++) begin                  // R6
            if (rv[t])                 n_pc[t] = rpc[t*PW +: PW];
            else if (e_v && e_s == t)  n_pc[t] = m_pc[t] + 32'd4;
            else                       n_pc[t] = m_pc[t];
        end
    endtask

    task automatic model_commit();
        m_ptr = n_ptr; m_cnt = n_cnt; m_last = n_last; m_refill = n_refill;
        for (int t = 0; t < 4; t++) m_pc[t] = n_pc[t];
    endtask

    // One cycle: compare at the falling edge, advance model at the rising edge.
    task automatic cyc(input string tag);
        bit e_v, e_f;
        int e_s;
        logic [31:0] e_pc;
        @(negedge clk);
        model_eval(e_v, e_s, e_f);
        e_pc = m_pc[e_s];
        nchecks++;
        if (sel !== 2'(e_s) || fv !== e_v || fl !== e_f || fpc !== e_pc) begin
            nerr++;
            $display("FAIL %s: sel/valid/flush/pc got %0d/%0b/%0b/%h expected %0d/%0b/%0b/%h",
                     tag, sel, fv, fl, fpc, e_s, e_v, e_f, e_pc);
        end
        @(posedge clk);
        model_commit();
        #1;
    endtask

    task automatic quiet();
        ss = '0; sl = '0; rv = '0; pref_en = 0; pref_id = '0;
    endtask

    initial begin
        int unsigned r;
        r = $urandom(11);
        rst_n = 0; mode_c = 0; wt = {4{3'd1}}; rpc = '0;
        quiet();
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        cyc("R1");
        repeat (8) cyc("R2");

        ss = 4'b0010; sl = 4'b0100;                   // skip 1 and 2
        repeat (6) cyc("R3");
        quiet();

        wt = {3'd1, 3'd2, 3'd1, 3'd3};                // t0=3 t1=1 t2=2 t3=1
        repeat (14) cyc("R4");
        ss = 4'b0001; repeat (2) cyc("R4");           // stall eats t0's turn
        quiet(); wt = {4{3'd1}};

        ss = 4'b1010; sl = 4'b0101;
        repeat (3) cyc("R5");
        quiet(); cyc("R5");

        rv = 4'b0100; rpc[2*PW +: PW] = 32'h0000_8000;
        cyc("R6");
        rv = 4'b0000; repeat (5) cyc("R6");
        rv = 4'b1111; rpc = {32'hA0, 32'hB0, 32'hC0, 32'hD0};
        cyc("R6");
        rv = '0; repeat (4) cyc("R6");

        mode_c = 1;
        repeat (3) cyc("R7");
        ss[m_last] = 1'b1; repeat (2) cyc("R7");
        quiet(); repeat (2) cyc("R7");

        sl[m_last] = 1'b1;
        repeat (6) cyc("R8");
        quiet();
        sl = 4'b1111; repeat (2) cyc("R8");         // long stall, nobody else ready
        quiet(); cyc("R8");

        sl[m_last] = 1'b1; cyc("R10");                // flush, then flip to fine
        quiet(); mode_c = 0;
        repeat (5) cyc("R10");
        mode_c = 1; sl[m_last] = 1'b1; cyc("R10");
        quiet(); mode_c = 0; cyc("R10");
        mode_c = 1; repeat (4) cyc("R10");

        mode_c = 0; pref_en = 1; pref_id = 2'd3;
        repeat (4) cyc("R9");
        ss = 4'b1000; repeat (3) cyc("R9");
        ss = '0; mode_c = 1; pref_id = 2'd1;
        repeat (6) cyc("R9");
        quiet();

        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 50 == 0) mode_c = ~mode_c;
            if ($urandom % 40 == 0) begin pref_en = ($urandom % 3 == 0); pref_id = 2'($urandom); end
            if ($urandom % 100 == 0) wt = 12'($urandom);
            for (int t = 0; t < 4; t++) begin
                ss[t] = ($urandom % 4 == 0);
                sl[t] = ($urandom % 9 == 0);
                rv[t] = ($urandom % 16 == 0);
                rpc[t*PW +: PW] = {$urandom} & 32'hFFFF_FFFC;
            end
            cyc("R11");
        end

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchecks++; nerr++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule